// File: doc/BRIEF.md
# Hashed Page Table Walker

This engine finds the translation entry for one page in a hashed page table kept in memory. A request gives the segment's virtual segment identifier, the effective address and whether the access is a store. The walker hashes these into a group address and reads the group one entry at a time over a plain memory port. Each read returns one word one cycle after it is issued, and the port can also write a single byte. If no entry in the first group matches, the walker searches a second group whose address comes from the inverted hash.

On a hit it returns both words of the entry and the physical address. It also writes back the referenced bit, and the changed bit when the access is a store. If the changed bit is still clear and the access is not a store, it withholds write permission. The table base and the table mask are configuration inputs. Judging the protection bits is left to the caller. The walker takes a new request only while it is idle.

Top module: `hpt_walker`

## Requirements
- R1: `req_ready` is high only when the walker is idle. It goes high in the cycle after `rsp_valid`. A request presented while `req_ready` is low, including in the response cycle, is dropped and produces no response.
- R2: The page index is `ea[27:12]`. The hash is `vsid[18:0]` XOR the zero-extended page index. The first word read is at `tbl_base + (({hash,6'b0}) & tbl_mask)`.
- R3: For each entry, word 0 at entry offset 0 is read before word 1 at offset 4, in the very next cycle. Consecutive entries are 8 bytes apart. Word 1 is read only when word 0 matches.
- R4: Word 0 holds valid in bit 31, the VSID in bits 30:7, the secondary flag in bit 6 and the tag in bits 5:0, which is page index >> 10. An entry matches only when it is valid, its secondary flag equals the current pass (0 for the first group, 1 for the second), and both its VSID and its tag are equal to those of the request.
- R5: After all 8 entries of the first group miss, the 8 entries of the group addressed by the bitwise complement of the 19-bit hash are searched.
- R6: Word 1 holds the real page number in bits 31:12, referenced in bit 8, changed in bit 7 and protection in bits 1:0. On a hit with referenced clear, one byte is written at entry offset 6. That byte holds word 1 bits 15:9 with bit 0 set. Bytes are big-endian within a word.
- R7: On a hit with changed clear and a store access, one byte is written at entry offset 7. That byte holds word 1 bits 6:0 with bit 7 set. No byte is written for a bit that is already set.
- R8: `rsp_wr_ok` is low exactly when the entry's changed bit was clear and the access was not a store.
- R9: On a hit, `rsp_paddr` is word 1 bits 31:12 joined with `ea[11:0]`, and `rsp_word0`/`rsp_word1` are the words as read.
- R10: If both groups miss, the walker gives one `rsp_valid` cycle with `rsp_hit` low and performs no writes.
- R11: After reset, `req_ready` is high and `rsp_valid`, `mem_rd_en` and `mem_wr_en` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tbl_base | input | ADDR_W | Byte address of the table |
| tbl_mask | input | ADDR_W | Mask applied to the shifted hash |
| req_valid | input | 1 | Request strobe |
| req_ready | output | 1 | Walker idle and accepting |
| req_vsid | input | 24 | Virtual segment identifier |
| req_ea | input | 32 | Effective address |
| req_store | input | 1 | Access is a store |
| mem_rd_en | output | 1 | Word read; data arrives next cycle |
| mem_wr_en | output | 1 | Single-byte write |
| mem_addr | output | ADDR_W | Byte address |
| mem_wbyte | output | 8 | Byte to write |
| mem_rdata | input | 32 | Read word |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_hit | output | 1 | Entry found |
| rsp_word0 | output | 32 | Matched entry word 0 |
| rsp_word1 | output | 32 | Matched entry word 1 |
| rsp_paddr | output | 32 | Physical address |
| rsp_wr_ok | output | 1 | Write permission not withheld |

## Verification
Two things can land in the same cycle. One is the response strobe and a new request from the requester. The other is the referenced update and the changed update, which one store hit on a fully clear entry triggers back to back. The bench holds a second request asserted through a whole walk, including the response cycle. It then expects exactly one response, carrying the first request's data. For the store case it seeds an entry with both bits clear. It expects two single-byte writes, at offsets 6 and then 7, with both bits set in memory afterwards and no other bit of the word disturbed.

// File: rtl/hpt_pkg.sv
package hpt_pkg;
    localparam int WORD_W = 32;
    localparam int VSID_W = 24;
    localparam int PIDX_W = 16;
    localparam int TAG_W  = 6;
    localparam int PG_SH  = 12;

    localparam int W0_VALID = 31;
    localparam int W0_SEC   = 6;
    localparam int W1_REF   = 8;
    localparam int W1_CHG   = 7;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RD0,
        ST_W0,
        ST_W1,
        ST_SETR,
        ST_SETC,
        ST_RSP
    } walk_st_e;
endpackage

// File: rtl/hpt_hash.sv
module hpt_hash
    import hpt_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int HASH_W = 19
) (
    input  logic [VSID_W-1:0] vsid,
    input  logic [31:0]       ea,
    input  logic              second,
    input  logic [ADDR_W-1:0] base,
    input  logic [ADDR_W-1:0] mask,
    output logic [ADDR_W-1:0] group_addr,
    output logic [TAG_W-1:0]  tag
);
    localparam int PAD_W = ADDR_W - HASH_W - 6;

    logic [PIDX_W-1:0] pidx;
    logic [HASH_W-1:0] hash, sel;
    logic [ADDR_W-1:0] off;

    always_comb begin
        pidx       = ea[27:PG_SH];
        hash       = vsid[HASH_W-1:0] ^ HASH_W'(pidx);
        sel        = second ? ~hash : hash;
        off        = {{PAD_W{1'b0}}, sel, 6'b0};
        group_addr = base + (off & mask);
        tag        = pidx[PIDX_W-1 -: TAG_W];
    end
endmodule

// File: rtl/hpt_match.sv
module hpt_match
    import hpt_pkg::*;
(
    input  logic [WORD_W-1:0] word0,
    input  logic [VSID_W-1:0] vsid,
    input  logic [TAG_W-1:0]  tag,
    input  logic              second,
    output logic              hit
);
    always_comb begin
        hit = word0[W0_VALID]
            && (word0[W0_SEC] == second)
            && (word0[30:7] == vsid)
            && (word0[TAG_W-1:0] == tag);
    end
endmodule

// File: rtl/hpt_walker.sv
module hpt_walker
    import hpt_pkg::*;
#(
    parameter int ADDR_W  = 32,
    parameter int HASH_W  = 19,
    parameter int GROUP_N = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] tbl_base,
    input  logic [ADDR_W-1:0] tbl_mask,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [VSID_W-1:0] req_vsid,
    input  logic [31:0]       req_ea,
    input  logic              req_store,
    output logic              mem_rd_en,
    output logic              mem_wr_en,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [7:0]        mem_wbyte,
    input  logic [31:0]       mem_rdata,
    output logic              rsp_valid,
    output logic              rsp_hit,
    output logic [31:0]       rsp_word0,
    output logic [31:0]       rsp_word1,
    output logic [31:0]       rsp_paddr,
    output logic              rsp_wr_ok
);
    localparam int IDX_W = $clog2(GROUP_N);
    localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(GROUP_N - 1);

    typedef struct packed {
        walk_st_e          st;
        logic              second;
        logic [IDX_W-1:0]  idx;
        logic [VSID_W-1:0] vsid;
        logic [31:0]       ea;
        logic              store;
        logic              hit;
        logic [31:0]       w0;
        logic [31:0]       w1;
    } walk_t;

    walk_t s_d, s_q;

    logic [ADDR_W-1:0] group_addr, entry_addr;
    logic [TAG_W-1:0]  tag;
    logic              w0_hit;

    hpt_hash #(.ADDR_W(ADDR_W), .HASH_W(HASH_W)) u_hash (
        .vsid(s_q.vsid), .ea(s_q.ea), .second(s_q.second),
        .base(tbl_base), .mask(tbl_mask),
        .group_addr(group_addr), .tag(tag)
    );

    hpt_match u_match (
        .word0(mem_rdata), .vsid(s_q.vsid), .tag(tag),
        .second(s_q.second), .hit(w0_hit)
    );

    assign entry_addr = group_addr + ADDR_W'({s_q.idx, 3'b000});

    always_comb begin
        s_d       = s_q;
        mem_rd_en = 1'b0;
        mem_wr_en = 1'b0;
        mem_addr  = entry_addr;
        mem_wbyte = 8'h00;
        unique case (s_q.st)
            ST_IDLE: begin
                if (req_valid) begin
                    s_d.st     = ST_RD0;
                    s_d.second = 1'b0;
                    s_d.idx    = '0;
                    s_d.vsid   = req_vsid;
                    s_d.ea     = req_ea;
                    s_d.store  = req_store;
                    s_d.hit    = 1'b0;
                end
            end
            ST_RD0: begin
                mem_rd_en = 1'b1;
                s_d.st    = ST_W0;
            end
            ST_W0: begin
                s_d.w0 = mem_rdata;
                if (w0_hit) begin
                    mem_rd_en = 1'b1;
                    mem_addr  = entry_addr + ADDR_W'(4);
                    s_d.st    = ST_W1;
                end else if (s_q.idx != IDX_LAST) begin
                    s_d.idx = s_q.idx + 1'b1;
                    s_d.st  = ST_RD0;
                end else if (!s_q.second) begin
                    s_d.second = 1'b1;
                    s_d.idx    = '0;
                    s_d.st     = ST_RD0;
                end else begin
                    s_d.st = ST_RSP;
                end
            end
            ST_W1: begin
                s_d.w1  = mem_rdata;
                s_d.hit = 1'b1;
                if (!mem_rdata[W1_REF])
                    s_d.st = ST_SETR;
                else if (!mem_rdata[W1_CHG] && s_q.store)
                    s_d.st = ST_SETC;
                else
                    s_d.st = ST_RSP;
            end
            ST_SETR: begin
                mem_wr_en = 1'b1;
                mem_addr  = entry_addr + ADDR_W'(6);
                mem_wbyte = {s_q.w1[15:9], 1'b1};
                s_d.st    = (!s_q.w1[W1_CHG] && s_q.store) ? ST_SETC : ST_RSP;
            end
            ST_SETC: begin
                mem_wr_en = 1'b1;
                mem_addr  = entry_addr + ADDR_W'(7);
                mem_wbyte = {1'b1, s_q.w1[6:0]};
                s_d.st    = ST_RSP;
            end
            ST_RSP: begin
                s_d.st = ST_IDLE;
            end
            default: s_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q    <= '0;
            s_q.st <= ST_IDLE;
        end else begin
            s_q <= s_d;
        end
    end

    assign req_ready = (s_q.st == ST_IDLE);
    assign rsp_valid = (s_q.st == ST_RSP);
    assign rsp_hit   = s_q.hit;
    assign rsp_word0 = s_q.w0;
    assign rsp_word1 = s_q.w1;
    assign rsp_paddr = {s_q.w1[31:PG_SH], s_q.ea[PG_SH-1:0]};
    assign rsp_wr_ok = s_q.w1[W1_CHG] | s_q.store;

    assert_one_port_op_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_rd_en && mem_wr_en));

    assert_word1_follows_word0_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd_en && mem_addr[2]) |-> ($past(mem_rd_en) && !$past(mem_addr[2])
                                        && $past(mem_addr) == mem_addr - ADDR_W'(4)));

    assert_ref_byte_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_wr_en && mem_addr[2:0] == 3'd6) |-> mem_wbyte[0]);

    assert_chg_byte_store_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_wr_en && mem_addr[2:0] == 3'd7) |-> (mem_wbyte[7] && s_q.store));

    assert_ready_after_rsp_R1: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> (req_ready && !rsp_valid));

    assert_no_write_on_miss_R10: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr_en |-> (!req_ready && !rsp_valid));
endmodule

// File: tb/hpt_walker_tb_top.sv
module hpt_walker_tb_top;
    logic        clk = 1'b0;
    logic        rst_n;
    logic [31:0] tbl_base = 32'h0000_1000;
    logic [31:0] tbl_mask = 32'h0000_0FC0;
    logic        req_valid;
    logic        req_ready;
    logic [23:0] req_vsid;
    logic [31:0] req_ea;
    logic        req_store;
    logic        mem_rd_en, mem_wr_en;
    logic [31:0] mem_addr;
    logic [7:0]  mem_wbyte;
    logic [31:0] mem_rdata;
    logic        rsp_valid, rsp_hit, rsp_wr_ok;
    logic [31:0] rsp_word0, rsp_word1, rsp_paddr;

    int n_chk = 0;
    int n_bad = 0;
    int n_w0rd, n_w1rd, n_wr, n_rsp;
    logic [31:0] first_rd, wr_a0, wr_a1;

    logic [31:0] mem [0:2047];

    always #5 clk = ~clk;

    hpt_walker dut_i (
        .clk(clk), .rst_n(rst_n), .tbl_base(tbl_base), .tbl_mask(tbl_mask),
        .req_valid(req_valid), .req_ready(req_ready), .req_vsid(req_vsid),
        .req_ea(req_ea), .req_store(req_store),
        .mem_rd_en(mem_rd_en), .mem_wr_en(mem_wr_en), .mem_addr(mem_addr),
        .mem_wbyte(mem_wbyte), .mem_rdata(mem_rdata),
        .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_word0(rsp_word0),
        .rsp_word1(rsp_word1), .rsp_paddr(rsp_paddr), .rsp_wr_ok(rsp_wr_ok)
    );

    always @(posedge clk) begin
        if (mem_rd_en) begin
            mem_rdata <= mem[mem_addr[12:2]];
            if (n_w0rd == 0 && !mem_addr[2]) first_rd <= mem_addr;
            if (mem_addr[2]) n_w1rd <= n_w1rd + 1;
            else             n_w0rd <= n_w0rd + 1;
        end
        if (mem_wr_en) begin
            mem[mem_addr[12:2]][8*(3-mem_addr[1:0]) +: 8] <= mem_wbyte;
            if (n_wr == 0) wr_a0 <= mem_addr;
            else           wr_a1 <= mem_addr;
            n_wr <= n_wr + 1;
        end
        if (rsp_valid) n_rsp <= n_rsp + 1;
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [18:0] hash_of(input logic [23:0] v, input logic [31:0] ea);
        return v[18:0] ^ {3'b0, ea[27:12]};
    endfunction

    function automatic logic [31:0] grp(input logic [18:0] h);
        return tbl_base + ({7'b0, h, 6'b0} & tbl_mask);
    endfunction

    function automatic logic [31:0] mk_w0(input logic v, input logic sec,
                                          input logic [23:0] vs, input logic [31:0] ea);
        return {v, vs, sec, ea[27:22]};
    endfunction

    function automatic logic [31:0] mk_w1(input logic [19:0] rpn, input logic r, input logic c);
        return {rpn, 3'b0, r, c, 5'b0, 2'b10};
    endfunction

    task automatic put(input logic [31:0] a, input logic [31:0] w0, input logic [31:0] w1);
        mem[a[12:2]]     = w0;
        mem[a[12:2] + 1] = w1;
    endtask

    task automatic clear_mem();
        for (int i = 0; i < 2048; i++) mem[i] = 32'h0;
    endtask

    task automatic walk(input logic [23:0] v, input logic [31:0] ea, input logic st);
        @(negedge clk);
        n_w0rd = 0; n_w1rd = 0; n_wr = 0; n_rsp = 0;
        req_valid = 1'b1; req_vsid = v; req_ea = ea; req_store = st;
        @(negedge clk);
        req_valid = 1'b0;
        for (int k = 0; k < 200 && !rsp_valid; k++) @(negedge clk);
    endtask

    task automatic t_reset();
        check("R11 ready", {31'b0, req_ready}, 32'h1);
        check("R11 rsp_valid", {31'b0, rsp_valid}, 32'h0);
        check("R11 rd_en", {31'b0, mem_rd_en}, 32'h0);
        check("R11 wr_en", {31'b0, mem_wr_en}, 32'h0);
    endtask

    task automatic t_primary_load();
        logic [23:0] v = 24'h000123;
        logic [31:0] ea = 32'h3456_7ABC;
        logic [31:0] g = grp(hash_of(v, ea));
        clear_mem();
        put(g + 8,  mk_w0(1'b0, 1'b0, v, ea), mk_w1(20'h11111, 1'b0, 1'b0));
        put(g + 16, mk_w0(1'b1, 1'b1, v, ea), mk_w1(20'h22222, 1'b0, 1'b0));
        put(g + 24, mk_w0(1'b1, 1'b0, v, ea), mk_w1(20'hABCDE, 1'b0, 1'b0));
        walk(v, ea, 1'b0);
        check("R2 first read addr", first_rd, g);
        check("R4 hit", {31'b0, rsp_hit}, 32'h1);
        check("R4 word0 skipped invalid/sec", rsp_word0, mk_w0(1'b1, 1'b0, v, ea));
        check("R3 word0 reads", n_w0rd, 4);
        check("R3 word1 reads", n_w1rd, 1);
        check("R9 paddr", rsp_paddr, 32'hABCDE_ABC);
        check("R9 word1", rsp_word1, mk_w1(20'hABCDE, 1'b0, 1'b0));
        check("R8 wr_ok load C clear", {31'b0, rsp_wr_ok}, 32'h0);
        @(negedge clk);
        check("R1 ready after rsp", {31'b0, req_ready}, 32'h1);
        check("R6 one write", n_wr, 1);
        check("R6 write addr", wr_a0, g + 30);
        check("R6 memory word1", mem[(g + 28) >> 2 & 2047], mk_w1(20'hABCDE, 1'b1, 1'b0));
        walk(v, ea, 1'b1);
        check("R7 store C write addr", wr_a0, g + 31);
        check("R7 store R already set one write", n_wr, 1);
        check("R8 wr_ok store", {31'b0, rsp_wr_ok}, 32'h1);
        @(negedge clk);
        check("R7 memory word1", mem[(g + 28) >> 2 & 2047], mk_w1(20'hABCDE, 1'b1, 1'b1));
    endtask

    task automatic t_store_both();
        logic [23:0] v = 24'h0A5A5A;
        logic [31:0] ea = 32'h7FFF_F123;
        logic [31:0] g = grp(hash_of(v, ea));
        clear_mem();
        put(g, mk_w0(1'b1, 1'b0, v, ea), 32'hFFFF_FE7F);
        walk(v, ea, 1'b1);
        @(negedge clk);
        check("R6 R7 two writes", n_wr, 2);
        check("R6 first at +6", wr_a0, g + 6);
        check("R7 second at +7", wr_a1, g + 7);
        check("R6 R7 word1 bits", mem[(g + 4) >> 2 & 2047], 32'hFFFF_FFFF);
    endtask

    task automatic t_secondary();
        logic [23:0] v = 24'h3C0C7;
        logic [31:0] ea = 32'h0120_4008;
        logic [31:0] gp = grp(hash_of(v, ea));
        logic [31:0] gs = grp(~hash_of(v, ea));
        clear_mem();
        for (int i = 0; i < 8; i++)
            put(gp + 8 * i, mk_w0(1'b1, 1'b0, v, ea ^ 32'h0400_0000), mk_w1(20'h1, 1'b1, 1'b1));
        put(gs + 40, mk_w0(1'b1, 1'b1, v, ea), mk_w1(20'h5A5A5, 1'b1, 1'b1));
        walk(v, ea, 1'b0);
        check("R5 hit", {31'b0, rsp_hit}, 32'h1);
        check("R5 word0 reads", n_w0rd, 14);
        check("R5 word0", rsp_word0, mk_w0(1'b1, 1'b1, v, ea));
        check("R9 paddr sec", rsp_paddr, 32'h5A5A5_008);
        check("R8 wr_ok C set", {31'b0, rsp_wr_ok}, 32'h1);
        @(negedge clk);
        check("R7 no write when set", n_wr, 0);
    endtask

    task automatic t_miss();
        logic [23:0] v = 24'h000051;
        logic [31:0] ea = 32'hC000_0000;
        clear_mem();
        put(grp(hash_of(v, ea)), mk_w0(1'b1, 1'b1, v, ea), mk_w1(20'h7, 1'b0, 1'b0));
        walk(v, ea, 1'b1);
        check("R10 rsp seen", {31'b0, rsp_valid}, 32'h1);
        check("R10 hit low", {31'b0, rsp_hit}, 32'h0);
        check("R10 word0 reads", n_w0rd, 16);
        @(negedge clk);
        check("R10 no writes", n_wr, 0);
    endtask

    task automatic t_busy_drop();
        logic [23:0] v = 24'h000777;
        logic [31:0] ea = 32'h1000_2345;
        logic [31:0] g = grp(hash_of(v, ea));
        clear_mem();
        put(g, mk_w0(1'b1, 1'b0, v, ea), mk_w1(20'h0BEEF, 1'b1, 1'b1));
        @(negedge clk);
        n_rsp = 0; n_wr = 0; n_w0rd = 0; n_w1rd = 0;
        req_valid = 1'b1; req_vsid = v; req_ea = ea; req_store = 1'b0;
        @(negedge clk);
        req_vsid = 24'h000888; req_ea = 32'h2000_0000;
        for (int k = 0; k < 50 && !rsp_valid; k++) @(negedge clk);
        check("R1 rsp of first req", rsp_paddr, 32'h0BEEF_345);
        @(negedge clk);
        req_valid = 1'b0;
        for (int k = 0; k < 60; k++) @(negedge clk);
        check("R1 single response", n_rsp, 1);
    endtask

    initial begin
        #2_000_000;
        n_chk++; n_bad++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        rst_n = 1'b0; req_valid = 1'b0; req_vsid = '0; req_ea = '0; req_store = 1'b0;
        mem_rdata = '0; n_w0rd = 0; n_w1rd = 0; n_wr = 0; n_rsp = 0;
        first_rd = '0; wr_a0 = '0; wr_a1 = '0;
        clear_mem();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_primary_load();
        t_store_both();
        t_secondary();
        t_miss();
        t_busy_drop();
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule